// File: doc/BRIEF.md
# UART FIFO Interrupt Request and Receive Watchdog

This block turns the occupancy counts of one UART channel's receive and transmit FIFOs into the channel's two interrupt requests. It also runs a receive inactivity watchdog. The FIFOs, the serial shifters, the baud generator and the host bus decode all sit outside the block. The block sees only the two fill counts, a strobe that pulses on every receive FIFO read or write, and a bit-time tick.

The receive threshold code is three bits wide. Its top bit comes from one mode register and its two low bits come from a second mode register. The code selects a fill level, and the receive request is raised when the FIFO holds at least that many bytes. The transmit threshold code is two bits wide and selects how many free positions must exist before the transmit request is raised. Both tables scale with a depth select that chooses an 8-entry or a 256-entry FIFO.

The watchdog catches a short tail of a message that stays unread below the threshold. After 64 bit times with no receive FIFO access while data is waiting, it forces the receive request. The request stays forced until the next access. A status output shows that the watchdog caused the request.

Top module: `uirq_ctrl`

## Requirements
- R1: The receive code is {rx_code_hi, rx_code_lo[1:0]}. Codes 0 to 5 select fill levels of 1, depth/4, depth/2, 3*depth/4, 7*depth/8 and depth bytes; codes 6 and 7 also select depth. rx_irq is high in the same cycle that rx_fill is at or above the selected level. With code 0, one byte is enough.
- R2: deep_sel = 0 selects a depth of 8 and deep_sel = 1 selects a depth of 256. The depth applies to both threshold tables, so the receive levels are 1,2,4,6,7,8 and 1,64,128,192,224,256.
- R3: The free count is depth - tx_fill. Transmit code 0 needs free == depth, code 1 needs free >= depth/4, code 2 needs free >= depth/2 and code 3 needs free >= 1. tx_irq is high only while tx_en is 1 and the condition holds.
- R4: With tx_fill = 0 after reset, tx_irq rises in the same cycle that tx_en rises. With code 0, a tx_fill of 1 removes tx_irq in that same cycle.
- R5: While wdog_en is 1 and rx_fill is not 0, each bit_tick pulse advances the watchdog count. The 64th pulse since the last access sets wdog_flag on that clock edge. While wdog_flag is 1, rx_irq is 1.
- R6: rx_access clears the watchdog count and wdog_flag on the next edge. Without an access, wdog_flag stays set while wdog_en is 1.
- R7: While rx_fill is 0 the watchdog count is held at zero. When wdog_en is 0 the count is held at zero and wdog_flag is cleared.
- R8: After reset, the watchdog count is zero and wdog_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fill | input | 9 | Receive FIFO occupancy in bytes |
| tx_fill | input | 9 | Transmit FIFO occupancy in bytes |
| rx_access | input | 1 | Pulses on any receive FIFO read or write |
| bit_tick | input | 1 | One-cycle pulse per receive bit time |
| tx_en | input | 1 | Transmitter enable |
| deep_sel | input | 1 | 0 = 8-entry FIFOs, 1 = 256-entry FIFOs |
| wdog_en | input | 1 | Watchdog enable |
| rx_code_hi | input | 1 | Receive threshold code bit 2 |
| rx_code_lo | input | 2 | Receive threshold code bits 1:0 |
| tx_code | input | 2 | Transmit threshold code |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| wdog_flag | output | 1 | Receive request was forced by the watchdog |

## Verification
The assertions assume that both fill counts stay within the selected depth. The subtraction for the free count and the threshold comparisons are valid only in that range. They also assume that rx_fill becomes non-zero only through the write side of the FIFO, which pulses rx_access. The stimulus keeps every count between 0 and the active depth, and it changes deep_sel only while both counts are inside the smaller range. The watchdog scenarios use tick spacings of one and three cycles, accesses in the middle of a count, empty periods and disable periods, so each rule that clears or holds the counter is reached from a non-zero count.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Receive fill level selected by a 3-bit code for a given FIFO depth.
  function automatic int unsigned rx_level(input logic [2:0] code, input int unsigned depth);
    int unsigned lvl;
    case (code)
      3'd0:    lvl = 1;
      3'd1:    lvl = depth / 4;
      3'd2:    lvl = depth / 2;
      3'd3:    lvl = (3 * depth) / 4;
      3'd4:    lvl = (7 * depth) / 8;
      default: lvl = depth;
    endcase
    return lvl;
  endfunction

  // Minimum number of free transmit positions for a 2-bit code.
  function automatic int unsigned tx_need(input logic [1:0] code, input int unsigned depth);
    int unsigned n;
    case (code)
      2'd0:    n = depth;
      2'd1:    n = depth / 4;
      2'd2:    n = depth / 2;
      default: n = 1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/uirq_rx_level.sv
module uirq_rx_level #(
  parameter int unsigned DEPTH_SMALL = 8,
  parameter int unsigned DEPTH_LARGE = 256,
  parameter int unsigned FILL_W      = 9
) (
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [2:0]        code,
  input  logic              deep_sel,
  output logic              level_hit
);
  import uirq_pkg::*;

  logic [FILL_W-1:0] lvl_small, lvl_large, lvl_sel;

  always_comb begin
    lvl_small = FILL_W'(rx_level(code, DEPTH_SMALL));
    lvl_large = FILL_W'(rx_level(code, DEPTH_LARGE));
    lvl_sel   = deep_sel ? lvl_large : lvl_small;
    level_hit = (rx_fill >= lvl_sel);
  end
endmodule

// File: rtl/uirq_tx_level.sv
module uirq_tx_level #(
  parameter int unsigned DEPTH_SMALL = 8,
  parameter int unsigned DEPTH_LARGE = 256,
  parameter int unsigned FILL_W      = 9
) (
  input  logic [FILL_W-1:0] tx_fill,
  input  logic [1:0]        code,
  input  logic              deep_sel,
  input  logic              tx_en,
  output logic              tx_req
);
  import uirq_pkg::*;

  localparam logic [FILL_W-1:0] DS = FILL_W'(DEPTH_SMALL);
  localparam logic [FILL_W-1:0] DL = FILL_W'(DEPTH_LARGE);

  logic [FILL_W-1:0] free_cnt, need;

  always_comb begin
    free_cnt = (deep_sel ? DL : DS) - tx_fill;
    need     = deep_sel ? FILL_W'(tx_need(code, DEPTH_LARGE))
                        : FILL_W'(tx_need(code, DEPTH_SMALL));
    tx_req   = tx_en && (free_cnt >= need);
  end
endmodule

// File: rtl/uirq_rx_wdog.sv
module uirq_rx_wdog #(
  parameter int unsigned WD_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_nz,
  input  logic access,
  input  logic tick,
  input  logic en,
  output logic flag
);
  localparam int unsigned CW = $clog2(WD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          clear_ev;
  logic          adv_ev;
  logic          expire_ev;

  assign clear_ev  = access || !en;
  assign adv_ev    = !clear_ev && fill_nz && tick && !flag;
  assign expire_ev = adv_ev && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (clear_ev) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (!fill_nz) begin
      cnt  <= '0;
    end else if (expire_ev) begin
      cnt  <= '0;
      flag <= 1'b1;
    end else if (adv_ev) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R6
  access_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> (!flag && cnt == '0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_nz || !en) |=> (cnt == '0));
  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && en && fill_nz && !access));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && en && !access) |=> flag);
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl #(
  parameter int unsigned DEPTH_SMALL = 8,
  parameter int unsigned DEPTH_LARGE = 256,
  parameter int unsigned WD_TICKS    = 64,
  parameter int unsigned FILL_W      = $clog2(DEPTH_LARGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic              rx_access,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              deep_sel,
  input  logic              wdog_en,
  input  logic              rx_code_hi,
  input  logic [1:0]        rx_code_lo,
  input  logic [1:0]        tx_code,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              wdog_flag
);
  logic [2:0] rx_code;
  logic       rx_hit;
  logic       rx_nz;

  assign rx_code = {rx_code_hi, rx_code_lo};
  assign rx_nz   = (rx_fill != '0);

  uirq_rx_level #(.DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE), .FILL_W(FILL_W))
    u_rxl (.rx_fill(rx_fill), .code(rx_code), .deep_sel(deep_sel), .level_hit(rx_hit));

  uirq_tx_level #(.DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE), .FILL_W(FILL_W))
    u_txl (.tx_fill(tx_fill), .code(tx_code), .deep_sel(deep_sel), .tx_en(tx_en),
           .tx_req(tx_irq));

  uirq_rx_wdog #(.WD_TICKS(WD_TICKS))
    u_wd (.clk(clk), .rst_n(rst_n), .fill_nz(rx_nz), .access(rx_access),
          .tick(bit_tick), .en(wdog_en), .flag(wdog_flag));

  assign rx_irq = rx_hit || wdog_flag;

  // R3
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_irq);
  // R5
  wd_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_flag |-> rx_irq);
  // R1
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_nz && !wdog_flag) |-> !rx_irq);
  // R4
  tx_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 2'd0 && tx_fill != '0) |-> !tx_irq);
endmodule

// File: tb/test_uirq_ctrl.sv
module test_uirq_ctrl;
  localparam int FW = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [FW-1:0] rx_fill, tx_fill;
  logic          rx_access, bit_tick, tx_en, deep_sel, wdog_en, rx_code_hi;
  logic [1:0]    rx_code_lo, tx_code;
  logic          rx_irq, tx_irq, wdog_flag;

  uirq_ctrl i_uirq_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .tx_fill(tx_fill),
    .rx_access(rx_access), .bit_tick(bit_tick), .tx_en(tx_en),
    .deep_sel(deep_sel), .wdog_en(wdog_en), .rx_code_hi(rx_code_hi),
    .rx_code_lo(rx_code_lo), .tx_code(tx_code), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .wdog_flag(wdog_flag));

  int    checks = 0;
  int    fails  = 0;
  int    m_cnt  = 0;
  bit    m_flag = 0;
  string req    = "R8";

  int small_rx[8] = '{1, 2, 4, 6, 7, 8, 8, 8};
  int large_rx[8] = '{1, 64, 128, 192, 224, 256, 256, 256};
  int small_tx[4] = '{8, 2, 4, 1};
  int large_tx[4] = '{256, 64, 128, 1};

  task automatic cmp(input string r, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic check_now();
    int code, lvl, depth, need;
    bit e_rx, e_tx;
    code  = {rx_code_hi, rx_code_lo};
    depth = deep_sel ? 256 : 8;
    lvl   = deep_sel ? large_rx[code] : small_rx[code];
    need  = deep_sel ? large_tx[tx_code] : small_tx[tx_code];
    e_rx  = (int'(rx_fill) >= lvl) || m_flag;
    e_tx  = tx_en && ((depth - int'(tx_fill)) >= need);
    cmp(req, "rx_irq", rx_irq, e_rx);
    cmp(req, "tx_irq", tx_irq, e_tx);
    cmp(req, "wdog_flag", wdog_flag, m_flag);
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0;
    end else if (rx_access || !wdog_en) begin
      m_cnt = 0; m_flag = 0;
    end else if (rx_fill == 0) begin
      m_cnt = 0;
    end else if (bit_tick && !m_flag) begin
      m_cnt++;
      if (m_cnt == 64) begin m_flag = 1; m_cnt = 0; end
    end
  endtask

  task automatic step();
    #1 check_now();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rx_fill = 0; tx_fill = 0; rx_access = 0; bit_tick = 0;
    tx_en = 0; deep_sel = 0; wdog_en = 0; rx_code_hi = 0; rx_code_lo = 0; tx_code = 0;
    @(negedge clk);
    req = "R8"; repeat (3) step();
    rst_n = 1; step();

    // R4: transmitter enable with empty FIFO, then one byte loaded
    req = "R4"; tx_en = 1; step();
    tx_fill = 1; step();
    tx_fill = 0; step();

    // R1 / R2: receive sweep, every code at both depths
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 8; c++) begin
        rx_fill = 0; deep_sel = d[0];
        rx_code_hi = c[2]; rx_code_lo = c[1:0];
        for (int f = 0; f <= (d ? 256 : 8); f++) begin
          req = d ? "R2" : "R1";
          rx_fill = FW'(f); rx_access = 1; step();
        end
        rx_access = 0; rx_fill = 0; step();
      end
    end

    // R3 / R2: transmit sweep, every code at both depths, enabled and disabled
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 4; c++) begin
        tx_fill = 0; deep_sel = d[0]; tx_code = c[1:0];
        for (int f = 0; f <= (d ? 256 : 8); f++) begin
          req = "R3"; tx_fill = FW'(f); tx_en = (f % 5) != 3; step();
        end
        tx_fill = 0; tx_en = 1; step();
      end
    end

    // R5: watchdog expiry with tick every cycle, code 7 (full) at depth 8
    deep_sel = 0; rx_code_hi = 1; rx_code_lo = 2'b11; tx_code = 0;
    wdog_en = 1; rx_fill = 1; rx_access = 1; req = "R5"; step();
    rx_access = 0; bit_tick = 1;
    for (int i = 0; i < 70; i++) step();
    // R6: access clears the flag; access in the middle of a count
    req = "R6"; rx_access = 1; step();
    rx_access = 0;
    for (int i = 0; i < 40; i++) step();
    rx_access = 1; step();
    rx_access = 0; bit_tick = 0;
    for (int i = 0; i < 210; i++) begin
      req = "R5"; bit_tick = (i % 3) == 0; step();
    end
    // R7: empty FIFO holds the count; flag kept until access
    req = "R7"; rx_fill = 0; bit_tick = 1;
    for (int i = 0; i < 80; i++) step();
    rx_fill = 3; rx_access = 1; step();
    rx_access = 0;
    for (int i = 0; i < 30; i++) step();
    rx_fill = 0;
    for (int i = 0; i < 10; i++) step();
    rx_fill = 3;
    for (int i = 0; i < 40; i++) step();
    // R7: disable clears flag and holds count
    wdog_en = 0;
    for (int i = 0; i < 100; i++) step();
    wdog_en = 1;
    for (int i = 0; i < 70; i++) step();
    // R8: reset in the middle of a count
    req = "R8"; rst_n = 0; step();
    rst_n = 1;
    for (int i = 0; i < 10; i++) step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule